// File: doc/BRIEF.md
# Bundle Immediate Slot Allocator

This block hands out the immediate slots of an instruction bundle while the bundle is being assembled. Each cycle at most one constant request arrives, carrying a value and a flag that says whether the value is a raw 32-bit pattern or a signed 64-bit integer. The block replies one cycle later with a 6-bit operand selector code. The code can name a hardwired constant, which needs no slot. It can name a freshly allocated 20-bit slot, or the lower slot of an adjacent pair for values that need more than 20 bits. Otherwise the reply is an error: either no room is left in the bundle, or the value cannot be held in 32 bits.

A bundle holds six slots of 20 bits each. The occupancy mask is visible at all times. A close strobe emits the packed 120-bit immediate field, then empties every slot and clears the mask. A request presented together with the close strobe is placed into the new, empty bundle.

Top module: `imm_slot_alloc`

## Requirements
- R1: The hardwired constant table has these selector codes and 32-bit raw values: 0x2E=0x00000001, 0x2F=0xFFFFFFFF, 0x30=0x00000000, 0x31=0x80000000, 0x32=0x3F800000, 0x33=0xBF800000, 0x34=0x40000000, 0x35=0xC0000000, 0x36=0x3F000000, 0x37=0xBF000000, 0x38=0x40490FDB, 0x39=0xC0490FDB, 0x3A=0x402DF854, 0x3B=0xC02DF854. A request that matches an entry returns that code, leaves the mask unchanged and raises no error, even when every slot is in use.
- R2: With req_w32_i=1, only req_value_i[31:0] is used, both for matching and for placement, and the upper bits are ignored. With req_w32_i=0, the 64-bit value matches an entry only if it equals the sign extension of that entry's raw value.
- R3: A value whose 32-bit form sign-extends from bit 19 takes the lowest-numbered free slot k. The code returned is 0x20+k, and slot k holds value bits [19:0].
- R4: A 32-bit value that does not fit 20 bits takes the lowest pair (k, k+1) with k even and both slots free. Slot k holds bits [19:0], slot k+1 holds bits [31:20] zero-padded to 20 bits, and the code returned is 0x20+k.
- R5: With req_w32_i=0, a value that does not sign-extend from bit 31 raises rsp_unpl_o with code 0, and the mask is unchanged.
- R6: When the needed single slot or even-aligned pair is not free, rsp_ovf_o is raised with code 0, and the mask and the slots are unchanged.
- R7: A request on one rising edge produces a one-cycle rsp_valid_o pulse after that edge. No request means rsp_valid_o is low.
- R8: On a close_i edge, field_o captures the slots, with slot k at bits [20k+19:20k], and field_valid_o pulses for one cycle. The slots and the mask are cleared on the same edge, and a request on that edge is allocated into the emptied bundle.
- R9: mask_o bit k is 1 exactly when slot k is occupied. After reset, mask_o, field_o, rsp_valid_o and field_valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Constant request strobe |
| req_value_i | input | 64 | Constant value |
| req_w32_i | input | 1 | 1: value is a raw 32-bit pattern in bits [31:0]; 0: signed 64-bit integer |
| close_i | input | 1 | Close the bundle and emit the field |
| rsp_valid_o | output | 1 | Response valid |
| rsp_code_o | output | 6 | Operand selector code |
| rsp_ovf_o | output | 1 | No free slot or pair |
| rsp_unpl_o | output | 1 | Value wider than 32 bits |
| mask_o | output | 6 | Slot occupancy mask |
| field_o | output | 120 | Packed immediate field of the closed bundle |
| field_valid_o | output | 1 | field_o updated this cycle |

## Verification
The assertions watch several properties on every cycle. They check that an error response or a constant hit never changes the mask, that a single-slot write only lands on a free slot, that pairs always start on an even slot, that a slot code names an occupied slot, and that a close with no request leaves an empty mask. They also check the one-cycle response timing and that error codes are zero. Only the bench scenarios can show the actual selector values, the lowest-first search order, the split of wide values across a pair, and the exact bit layout of the emitted field. The same holds for the case where a pair is refused while an odd single slot is still free.

// File: rtl/imm_alloc_pkg.sv
package imm_alloc_pkg;
  localparam int CODE_W    = 6;
  localparam int NUM_CONST = 14;
  localparam logic [CODE_W-1:0] SLOT_BASE_CODE  = 6'h20;
  localparam logic [CODE_W-1:0] CONST_BASE_CODE = 6'h2E;

  // raw value for constant entry idx (code = CONST_BASE_CODE + idx)
  function automatic logic [31:0] const_raw(input int idx);
    logic [31:0] r;
    case (idx)
      0:       r = 32'h0000_0001;
      1:       r = 32'hFFFF_FFFF;
      2:       r = 32'h0000_0000;
      3:       r = 32'h8000_0000;
      4:       r = 32'h3F80_0000;
      5:       r = 32'hBF80_0000;
      6:       r = 32'h4000_0000;
      7:       r = 32'hC000_0000;
      8:       r = 32'h3F00_0000;
      9:       r = 32'hBF00_0000;
      10:      r = 32'h4049_0FDB;
      11:      r = 32'hC049_0FDB;
      12:      r = 32'h402D_F854;
      default: r = 32'hC02D_F854;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/imm_const_match.sv
module imm_const_match
  import imm_alloc_pkg::*;
#(
  parameter int VAL_W = 64
) (
  input  logic [VAL_W-1:0]  value_i,
  input  logic              w32_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int EXT_W = VAL_W - 32;

  logic [NUM_CONST-1:0] match;

  for (genvar i = 0; i < NUM_CONST; i++) begin : g_ent
    localparam logic [31:0] RAW = const_raw(i);
    assign match[i] = w32_i ? (value_i[31:0] == RAW)
                            : (value_i == {{EXT_W{RAW[31]}}, RAW});
  end

  always_comb begin
    hit_o  = |match;
    code_o = '0;
    for (int i = NUM_CONST - 1; i >= 0; i--) begin
      if (match[i]) code_o = CONST_BASE_CODE + CODE_W'(i);
    end
  end
endmodule

// File: rtl/imm_slot_finder.sv
module imm_slot_finder #(
  parameter int NUM_SLOTS = 6,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int NUM_PAIRS = NUM_SLOTS / 2
) (
  input  logic [NUM_SLOTS-1:0] mask_i,
  output logic                 single_ok_o,
  output logic [IDX_W-1:0]     single_idx_o,
  output logic                 pair_ok_o,
  output logic [IDX_W-1:0]     pair_idx_o
);
  logic [NUM_PAIRS-1:0] pair_free;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pair_free[p] = ~mask_i[2*p] & ~mask_i[2*p+1];
  end

  // downward scan so the lowest index wins
  always_comb begin
    single_ok_o  = 1'b0;
    single_idx_o = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (!mask_i[k]) begin
        single_ok_o  = 1'b1;
        single_idx_o = IDX_W'(k);
      end
    end
  end

  always_comb begin
    pair_ok_o  = 1'b0;
    pair_idx_o = '0;
    for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
      if (pair_free[p]) begin
        pair_ok_o  = 1'b1;
        pair_idx_o = IDX_W'(2 * p);
      end
    end
  end
endmodule

// File: rtl/imm_slot_store.sv
module imm_slot_store #(
  parameter int NUM_SLOTS = 6,
  parameter int SLOT_W    = 20,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int FIELD_W  = NUM_SLOTS * SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 close_i,
  input  logic                 wr_single_i,
  input  logic                 wr_pair_i,
  input  logic [IDX_W-1:0]     wr_idx_i,
  input  logic [SLOT_W-1:0]    lo_i,
  input  logic [SLOT_W-1:0]    hi_i,
  output logic [NUM_SLOTS-1:0] mask_o,
  output logic [FIELD_W-1:0]   field_o,
  output logic                 field_valid_o
);
  logic [SLOT_W-1:0]    slots_q [NUM_SLOTS];
  logic [SLOT_W-1:0]    slots_d [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] mask_q, mask_d;
  logic [FIELD_W-1:0]   packed_w, field_q;
  logic                 field_valid_q;

  always_comb begin
    for (int k = 0; k < NUM_SLOTS; k++) packed_w[k*SLOT_W +: SLOT_W] = slots_q[k];
  end

  // close empties the bundle first, then this cycle's write lands in it
  always_comb begin
    int base;
    base   = int'(wr_idx_i);
    mask_d = close_i ? '0 : mask_q;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      slots_d[k] = close_i ? '0 : slots_q[k];
      if ((wr_single_i || wr_pair_i) && base == k) begin
        slots_d[k] = lo_i;
        mask_d[k]  = 1'b1;
      end
      if (wr_pair_i && base + 1 == k) begin
        slots_d[k] = hi_i;
        mask_d[k]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q        <= '0;
      field_q       <= '0;
      field_valid_q <= 1'b0;
      for (int k = 0; k < NUM_SLOTS; k++) slots_q[k] <= '0;
    end else begin
      mask_q        <= mask_d;
      field_valid_q <= close_i;
      if (close_i) field_q <= packed_w;
      for (int k = 0; k < NUM_SLOTS; k++) slots_q[k] <= slots_d[k];
    end
  end

  assign mask_o        = mask_q;
  assign field_o       = field_q;
  assign field_valid_o = field_valid_q;

  AST_PAIR_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pair_i |-> !wr_idx_i[0]); // R4
  AST_SINGLE_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_single_i && !close_i) |-> !mask_q[wr_idx_i]); // R3
  AST_CLOSE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_i && !wr_single_i && !wr_pair_i) |=> (mask_q == '0)); // R8
endmodule

// File: rtl/imm_slot_alloc.sv
module imm_slot_alloc
  import imm_alloc_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int SLOT_W    = 20,
  parameter int VAL_W     = 64,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int FIELD_W  = NUM_SLOTS * SLOT_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [VAL_W-1:0]     req_value_i,
  input  logic                 req_w32_i,
  input  logic                 close_i,
  output logic                 rsp_valid_o,
  output logic [CODE_W-1:0]    rsp_code_o,
  output logic                 rsp_ovf_o,
  output logic                 rsp_unpl_o,
  output logic [NUM_SLOTS-1:0] mask_o,
  output logic [FIELD_W-1:0]   field_o,
  output logic                 field_valid_o
);
  logic              c_hit;
  logic [CODE_W-1:0] c_code;
  logic [31:0]       key32;
  logic              fits32, fits20;
  logic [NUM_SLOTS-1:0] mask_eff;
  logic              s_ok, p_ok;
  logic [IDX_W-1:0]  s_idx, p_idx;
  logic              wr_single, wr_pair;
  logic [IDX_W-1:0]  wr_idx;
  logic [CODE_W-1:0] code_d;
  logic              ovf_d, unpl_d;
  logic              rsp_valid_q, rsp_ovf_q, rsp_unpl_q;
  logic [CODE_W-1:0] rsp_code_q;

  imm_const_match #(.VAL_W(VAL_W)) u_match (
    .value_i (req_value_i),
    .w32_i   (req_w32_i),
    .hit_o   (c_hit),
    .code_o  (c_code)
  );

  assign key32  = req_value_i[31:0];
  assign fits32 = req_w32_i | (&req_value_i[VAL_W-1:31]) | ~(|req_value_i[VAL_W-1:31]);
  assign fits20 = (&key32[31:SLOT_W-1]) | ~(|key32[31:SLOT_W-1]);

  assign mask_eff = close_i ? '0 : mask_o;

  imm_slot_finder #(.NUM_SLOTS(NUM_SLOTS)) u_find (
    .mask_i       (mask_eff),
    .single_ok_o  (s_ok),
    .single_idx_o (s_idx),
    .pair_ok_o    (p_ok),
    .pair_idx_o   (p_idx)
  );

  // constant > unplaceable > slot placement
  always_comb begin
    wr_single = 1'b0;
    wr_pair   = 1'b0;
    wr_idx    = '0;
    code_d    = '0;
    ovf_d     = 1'b0;
    unpl_d    = 1'b0;
    if (req_valid_i) begin
      if (c_hit) begin
        code_d = c_code;
      end else if (!fits32) begin
        unpl_d = 1'b1;
      end else if (fits20) begin
        if (s_ok) begin
          wr_single = 1'b1;
          wr_idx    = s_idx;
          code_d    = SLOT_BASE_CODE + CODE_W'(s_idx);
        end else begin
          ovf_d = 1'b1;
        end
      end else if (p_ok) begin
        wr_pair = 1'b1;
        wr_idx  = p_idx;
        code_d  = SLOT_BASE_CODE + CODE_W'(p_idx);
      end else begin
        ovf_d = 1'b1;
      end
    end
  end

  imm_slot_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .close_i       (close_i),
    .wr_single_i   (wr_single),
    .wr_pair_i     (wr_pair),
    .wr_idx_i      (wr_idx),
    .lo_i          (key32[SLOT_W-1:0]),
    .hi_i          (SLOT_W'(key32 >> SLOT_W)),
    .mask_o        (mask_o),
    .field_o       (field_o),
    .field_valid_o (field_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_code_q  <= '0;
      rsp_ovf_q   <= 1'b0;
      rsp_unpl_q  <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid_i;
      rsp_code_q  <= code_d;
      rsp_ovf_q   <= ovf_d;
      rsp_unpl_q  <= unpl_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_code_o  = rsp_code_q;
  assign rsp_ovf_o   = rsp_ovf_q;
  assign rsp_unpl_o  = rsp_unpl_q;

  AST_NO_OVERFLOW_GROWTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ovf_o && !field_valid_o) |-> $stable(mask_o)); // R6
  AST_UNPL_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_unpl_o && !field_valid_o) |-> $stable(mask_o)); // R5
  AST_CONST_NO_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_code_o >= CONST_BASE_CODE && !field_valid_o) |-> $stable(mask_o)); // R1
  AST_SLOT_OCCUPIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ovf_o && !rsp_unpl_o && rsp_code_o < CONST_BASE_CODE)
    |-> mask_o[rsp_code_o[IDX_W-1:0]]); // R3
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R7
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R7
  AST_ERR_CODE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ovf_o || rsp_unpl_o) |-> (rsp_code_o == '0 && $countones({rsp_ovf_o, rsp_unpl_o}) == 1)); // R5
endmodule

// File: tb/imm_slot_alloc_bench.sv
module imm_slot_alloc_bench;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [63:0]  req_value_i = '0;
  logic         req_w32_i = 1'b0;
  logic         close_i = 1'b0;
  logic         rsp_valid_o;
  logic [5:0]   rsp_code_o;
  logic         rsp_ovf_o, rsp_unpl_o;
  logic [5:0]   mask_o;
  logic [119:0] field_o;
  logic         field_valid_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  imm_slot_alloc u_imm_slot_alloc (
    .clk_i, .rst_ni, .req_valid_i, .req_value_i, .req_w32_i, .close_i,
    .rsp_valid_o, .rsp_code_o, .rsp_ovf_o, .rsp_unpl_o,
    .mask_o, .field_o, .field_valid_o
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic [63:0] v, input bit w32, input logic [5:0] ecode,
                     input bit eovf, input bit eunpl, input logic [5:0] emask, input string tag);
    req_valid_i = 1'b1; req_value_i = v; req_w32_i = w32;
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(rsp_valid_o == 1'b1, {tag, " valid"}, 128'(rsp_valid_o), 128'(1));
    chk(rsp_code_o == ecode, {tag, " code"}, 128'(rsp_code_o), 128'(ecode));
    chk(rsp_ovf_o == eovf, {tag, " ovf"}, 128'(rsp_ovf_o), 128'(eovf));
    chk(rsp_unpl_o == eunpl, {tag, " unpl"}, 128'(rsp_unpl_o), 128'(eunpl));
    chk(mask_o == emask, {tag, " mask"}, 128'(mask_o), 128'(emask));
  endtask

  task automatic close_bundle(input logic [119:0] efield, input string tag);
    close_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    close_i = 1'b0;
    chk(field_valid_o == 1'b1, {tag, " field_valid"}, 128'(field_valid_o), 128'(1));
    chk(field_o == efield, {tag, " field"}, 128'(field_o), 128'(efield));
    chk(mask_o == 6'h00, {tag, " mask cleared"}, 128'(mask_o), 128'(0));
  endtask

  task automatic t_reset();
    chk(mask_o == '0, "R9 reset mask", 128'(mask_o), 128'(0));
    chk(rsp_valid_o == 1'b0, "R9 reset rsp_valid", 128'(rsp_valid_o), 128'(0));
    chk(field_valid_o == 1'b0, "R9 reset field_valid", 128'(field_valid_o), 128'(0));
    chk(field_o == '0, "R9 reset field", 128'(field_o), 128'(0));
  endtask

  task automatic t_constants();
    logic [31:0] raw [14];
    raw = '{32'h00000001, 32'hFFFFFFFF, 32'h00000000, 32'h80000000, 32'h3F800000,
            32'hBF800000, 32'h40000000, 32'hC0000000, 32'h3F000000, 32'hBF000000,
            32'h40490FDB, 32'hC0490FDB, 32'h402DF854, 32'hC02DF854};
    for (int i = 0; i < 14; i++)
      req({32'h0, raw[i]}, 1'b1, 6'(8'h2E + i), 0, 0, 6'h00, "R1 const table");
    req(64'hABCD_0000_0000_0001, 1'b1, 6'h2E, 0, 0, 6'h00, "R2 upper bits ignored");
    req(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'h2F, 0, 0, 6'h00, "R2 64-bit minus one");
    req(64'hFFFF_FFFF_8000_0000, 1'b0, 6'h31, 0, 0, 6'h00, "R2 64-bit sext match");
    req(64'h0000_0000_FFFF_FFFF, 1'b0, 6'h00, 0, 1, 6'h00, "R5 positive 2^32-1");
    req(64'h0000_0001_0000_0000, 1'b0, 6'h00, 0, 1, 6'h00, "R5 2^32");
    @(negedge clk_i);
    chk(rsp_valid_o == 1'b0, "R7 idle no response", 128'(rsp_valid_o), 128'(0));
  endtask

  task automatic t_fill_narrow_then_pair();
    req(64'd5, 1'b0, 6'h20, 0, 0, 6'h01, "R3 narrow slot0");
    req(-64'sd5, 1'b0, 6'h21, 0, 0, 6'h03, "R3 negative slot1");
    req(64'h7FFFF, 1'b0, 6'h22, 0, 0, 6'h07, "R3 max 20-bit");
    req(-64'sh80000, 1'b0, 6'h23, 0, 0, 6'h0F, "R3 min 20-bit");
    req(64'h1234_5678, 1'b0, 6'h24, 0, 0, 6'h3F, "R4 pair at 4");
    req(64'd7, 1'b0, 6'h00, 1, 0, 6'h3F, "R6 full single");
    req(64'd1, 1'b0, 6'h2E, 0, 0, 6'h3F, "R1 const while full");
    close_bundle({20'h00123, 20'h45678, 20'h80000, 20'h7FFFF, 20'hFFFFB, 20'h00005}, "R8 close full");
  endtask

  task automatic t_pair_alignment();
    req(64'h9, 1'b1, 6'h20, 0, 0, 6'h01, "R3 w32 narrow");
    req(64'hDEAD_BEEF, 1'b1, 6'h22, 0, 0, 6'h0D, "R4 pair skips odd");
    req(64'h10, 1'b1, 6'h21, 0, 0, 6'h0F, "R3 fills hole slot1");
    req(64'h11, 1'b1, 6'h24, 0, 0, 6'h1F, "R3 slot4");
    req(64'h7654_3210, 1'b1, 6'h00, 1, 0, 6'h1F, "R6 no even pair");
    req(64'h12, 1'b1, 6'h25, 0, 0, 6'h3F, "R3 odd slot5");
    req(64'hFFFF_FFF0, 1'b1, 6'h00, 1, 0, 6'h3F, "R6 full w32");
    close_bundle({20'h00012, 20'h00011, 20'h00DEA, 20'hDBEEF, 20'h00010, 20'h00009}, "R8 close mixed");
  endtask

  task automatic t_close_with_request();
    req(64'h80000, 1'b0, 6'h20, 0, 0, 6'h03, "R4 2^19 needs pair");
    req_valid_i = 1'b1; req_value_i = 64'd3; req_w32_i = 1'b0; close_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0; close_i = 1'b0;
    chk(field_o == {80'h0, 20'h00000, 20'h80000}, "R8 close+req field", 128'(field_o),
        128'({80'h0, 20'h00000, 20'h80000}));
    chk(rsp_code_o == 6'h20, "R8 req into new bundle code", 128'(rsp_code_o), 128'(6'h20));
    chk(mask_o == 6'h01, "R8 req into new bundle mask", 128'(mask_o), 128'(1));
    close_bundle({100'h0, 20'h00003}, "R8 second close");
    @(negedge clk_i);
    chk(field_valid_o == 1'b0, "R8 field_valid one pulse", 128'(field_valid_o), 128'(0));
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_constants();
    t_fill_narrow_then_pair();
    t_pair_alignment();
    t_close_with_request();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule